// File: doc/BRIEF.md
# Serial Mode-Control Port

This block is a slave on a three-wire serial link: an enable line, a serial clock and a data line that is shared in both directions. A controller raises the enable, shifts in a 16-bit control word with the least significant bit first, and watches for the slave to pull the data line low as an acknowledge. The lower byte of the word is an address that must equal a fixed code. The upper byte holds eight mode bits, which go into a register whose fields drive the rest of the chip.

All three serial lines are sampled by the block's own system clock through a synchronizer chain, and edges are found on the synchronized copies. The serial clock must therefore run well below the system clock. The open-drain pull-down on the data line is shown as an output-enable (`ack_oe`): while it is high, the pad drives the line low.

A word is accepted on the 16th rising serial-clock edge of a frame. A frame cut short is thrown away, and bits after the 16th are ignored. A separate clear input lets the calibration logic drop the start bit once its sequence has finished.

Top module: `serial_mode_port`

## Requirements
- R1: After reset, every mode field is 0 and `ack_oe` is 0.
- R2: Bits are taken least significant first. Word bits [7:0] are the address. Bits [15:8] map as follows: [15:14] `test_sel`, [13] `cal_dis`, [12] `cal_start`, [11] `sleep`, [10] `polar`, [9] `coef_meas`, [8] `gain_sel`.
- R3: The register is updated on the 16th rising serial-clock edge of a frame, while enable is still high.
- R4: `ack_oe` is 0 after the 16th rising edge. It goes to 1 only on the serial-clock falling edge that follows.
- R5: Once raised, `ack_oe` stays at 1 for as long as enable is high, and returns to 0 when enable falls.
- R6: A frame that ends (enable falls) after 15 or fewer rising edges leaves the register unchanged and gives no acknowledge.
- R7: A frame of more than 16 rising edges loads the first 16 bits. The later bits have no effect on the register.
- R8: A word whose address byte is not 8'h3C (default `ADDR_CODE`) leaves the register unchanged and gives no acknowledge.
- R9: A one-cycle pulse on `start_clr` sets `cal_start` to 0 and leaves the other fields unchanged.
- R10: The bit count and the partial word are cleared while enable is low, so a short frame does not corrupt the next full frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sen | input | 1 | Serial enable; high marks a frame |
| sclk | input | 1 | Serial clock from the controller |
| sdata_in | input | 1 | Level seen on the shared data line |
| start_clr | input | 1 | Pulse that clears the calibration-start field |
| sdata_oe | output | 1 | Enables the pull-down on the data line (acknowledge) |
| test_sel | output | 2 | Test-mode select field |
| cal_dis | output | 1 | Calibration-result disable field |
| cal_start | output | 1 | Calibration-start field |
| sleep | output | 1 | Sleep field |
| polar | output | 1 | Edge-polarity field |
| coef_meas | output | 1 | Coefficient-measurement field |
| gain_sel | output | 1 | Gain-select field |

## Verification
The port is driven with full 16-edge frames that carry several bit patterns: alternating bits, complementary bytes and single-bit fields. These show that the LSB-first order and the field mapping are right. Frames of 10 and 15 edges show that frames which end early are dropped. A 20-edge frame whose extra bits are the complement of the word shows that the load happens on the 16th edge and not on the last one. A frame whose address differs by one bit shows that the address is compared, and a full frame sent right after a short one shows that the counter is cleared between frames. The acknowledge is checked at three points: after the 16th rise, after the following fall, and after enable drops. These checks separate an acknowledge raised too early from one that is not held.

// File: rtl/smp_pkg.sv
// Package: shared types and constants for the serial mode-control port.
// Assumes the mode byte sits directly above the address field of the word.
package smp_pkg;

    // Mode fields in word order, most significant first.
    typedef struct packed {
        logic [1:0] test_sel;
        logic       cal_dis;
        logic       cal_start;
        logic       sleep;
        logic       polar;
        logic       coef_meas;
        logic       gain_sel;
    } mode_fields_t;

    localparam int FIELD_W = $bits(mode_fields_t);

endpackage

// File: rtl/smp_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each input is a level that stays put for several clocks at a time.
module smp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: first capture of the raw inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                // Purpose: later stage that lets metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/smp_rx.sv
// Module: frame receiver. It shifts in bits LSB first on serial-clock rises
// and pulses `accept` one cycle after the 16th rise if the address matches.
// Assumes sclk_rise is a one-cycle pulse in the system-clock domain.
module smp_rx #(
    parameter int                WORD_W    = 16,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] ADDR_CODE = 8'h3C,
    localparam int               CNT_W     = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sen_s,
    input  logic              sclk_rise,
    input  logic              din_s,
    output logic              accept,
    output logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  bit_cnt
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

    logic [WORD_W-1:0] shreg;
    logic              done_q;

    // Purpose: count bits and shift them in; everything clears while enable is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!sen_s) begin
                bit_cnt <= '0;
                shreg   <= '0;
            end else if (sclk_rise && (bit_cnt != FULL_CNT)) begin
                shreg   <= {din_s, shreg[WORD_W-1:1]};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_IDX) done_q <= 1'b1;
            end
        end
    end

    assign word   = shreg;
    assign accept = done_q && (shreg[ADDR_W-1:0] == ADDR_CODE);

endmodule

// File: rtl/smp_ackgen.sv
// Module: acknowledge generator. It arms on an accepted word, raises the
// pull-down enable on the next serial-clock fall, and holds it until enable drops.
// Assumes sclk_fall is a one-cycle pulse in the system-clock domain.
module smp_ackgen (
    input  logic clk,
    input  logic rst_n,
    input  logic sen_s,
    input  logic accept,
    input  logic sclk_fall,
    output logic ack_oe
);

    logic armed;

    // Purpose: remember that a word was accepted in this frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !sen_s) armed <= 1'b0;
        else if (accept)      armed <= 1'b1;
    end

    // Purpose: raise the acknowledge on the fall after acceptance, hold it until enable drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !sen_s)      ack_oe <= 1'b0;
        else if (armed && sclk_fall) ack_oe <= 1'b1;
    end

endmodule

// File: rtl/smp_regs.sv
// Module: mode register. It loads the mode byte on an accepted word; a clear
// pulse drops only the calibration-start field. A load in the same cycle as
// a clear wins.
module smp_regs
    import smp_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  mode_fields_t load_val,
    input  logic         start_clr,
    output mode_fields_t fields
);

    // Purpose: hold the mode fields; reset clears them all.
    always_ff @(posedge clk) begin
        if (!rst_n)         fields <= '0;
        else if (load)      fields <= load_val;
        else if (start_clr) fields.cal_start <= 1'b0;
    end

endmodule

// File: rtl/serial_mode_port.sv
// Module: top of the three-wire serial mode-control port. It synchronizes the
// serial lines, finds serial-clock edges, receives words, drives the
// acknowledge enable and holds the mode register.
// Assumes the serial clock half-period is longer than SYNC_STAGES + 2 system clocks.
module serial_mode_port
    import smp_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] ADDR_CODE   = 8'h3C,
    parameter int                SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sen,
    input  logic       sclk,
    input  logic       sdata_in,
    input  logic       start_clr,
    output logic       sdata_oe,
    output logic [1:0] test_sel,
    output logic       cal_dis,
    output logic       cal_start,
    output logic       sleep,
    output logic       polar,
    output logic       coef_meas,
    output logic       gain_sel
);

    localparam int WORD_W = ADDR_W + FIELD_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    logic [2:0]        pins_s;
    logic              sen_s, sclk_s, din_s, sclk_prev;
    logic              sclk_rise, sclk_fall;
    logic              accept;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  bit_cnt;
    mode_fields_t      fields;

    smp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sen, sclk, sdata_in}),
        .q     (pins_s)
    );

    assign {sen_s, sclk_s, din_s} = pins_s;

    // Purpose: keep the previous synchronized serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end

    assign sclk_rise = sclk_s && !sclk_prev;
    assign sclk_fall = !sclk_s && sclk_prev;

    smp_rx #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .ADDR_CODE(ADDR_CODE)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sen_s     (sen_s),
        .sclk_rise (sclk_rise),
        .din_s     (din_s),
        .accept    (accept),
        .word      (word),
        .bit_cnt   (bit_cnt)
    );

    smp_ackgen u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .sen_s     (sen_s),
        .accept    (accept),
        .sclk_fall (sclk_fall),
        .ack_oe    (sdata_oe)
    );

    smp_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_val  (mode_fields_t'(word[WORD_W-1:ADDR_W])),
        .start_clr (start_clr),
        .fields    (fields)
    );

    assign test_sel  = fields.test_sel;
    assign cal_dis   = fields.cal_dis;
    assign cal_start = fields.cal_start;
    assign sleep     = fields.sleep;
    assign polar     = fields.polar;
    assign coef_meas = fields.coef_meas;
    assign gain_sel  = fields.gain_sel;

endmodule

// File: rtl/smp_chk.sv
// Module: assertion checker bound into serial_mode_port. It watches the
// acknowledge timing, the register stability and the start-clear behaviour.
module smp_chk
    import smp_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sen_s,
    input logic             sclk_fall,
    input logic             sdata_oe,
    input logic             accept,
    input logic             start_clr,
    input logic [CNT_W-1:0] bit_cnt,
    input mode_fields_t     fields
);

    // R3: a load happens only when the 16th bit has just been counted.
    p_load_at_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (bit_cnt == CNT_W'(WORD_W)));

    // R4: the acknowledge rises only in the cycle after a serial-clock fall.
    p_ack_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdata_oe) |-> $past(sclk_fall));

    // R5: the acknowledge is held while enable stays high.
    p_ack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_oe && sen_s) |=> sdata_oe);

    // R5: the acknowledge is released once enable is low.
    p_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sen_s |=> !sdata_oe);

    // R6: with no load, every field except the start bit keeps its value.
    p_hold_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(fields.test_sel) && $stable(fields.cal_dis) &&
                     $stable(fields.sleep) && $stable(fields.polar) &&
                     $stable(fields.coef_meas) && $stable(fields.gain_sel)));

    // R9: a clear without a load leaves the start bit at 0.
    p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_clr && !accept) |=> !fields.cal_start);

endmodule

bind serial_mode_port smp_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sen_s     (sen_s),
    .sclk_fall (sclk_fall),
    .sdata_oe  (sdata_oe),
    .accept    (accept),
    .start_clr (start_clr),
    .bit_cnt   (bit_cnt),
    .fields    (fields)
);

// File: tb/tb_serial_mode_port.sv
// Bench: a table of frames with the expected register and acknowledge,
// followed by directed tests for reset and start-clear.
module tb_serial_mode_port;

    localparam int H = 6;

    typedef struct packed {
        logic [15:0] w;
        logic [7:0]  n;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{16'hA53C, 8'd16},  // R2 R3 alternating bits
        '{16'h5A3C, 8'd16},  // R2 complement pattern
        '{16'hFF3C, 8'd10},  // R6 short frame
        '{16'h0F3C, 8'd20},  // R7 long frame
        '{16'hF03D, 8'd16},  // R8 address off by one bit
        '{16'hC33C, 8'd15},  // R6 one edge short
        '{16'h693C, 8'd16}   // R10 full frame after a short one
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sen = 1'b0, sclk = 1'b0, sdata_in = 1'b1, start_clr = 1'b0;
    logic sdata_oe;
    logic [1:0] test_sel;
    logic cal_dis, cal_start, sleep, polar, coef_meas, gain_sel;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic ack_seen = 1'b0;
    logic [7:0] model = 8'h00;

    always #10 clk = ~clk;

    serial_mode_port dut (
        .clk(clk), .rst_n(rst_n), .sen(sen), .sclk(sclk), .sdata_in(sdata_in),
        .start_clr(start_clr), .sdata_oe(sdata_oe), .test_sel(test_sel),
        .cal_dis(cal_dis), .cal_start(cal_start), .sleep(sleep), .polar(polar),
        .coef_meas(coef_meas), .gain_sel(gain_sel)
    );

    function automatic logic [7:0] fields_now();
        return {test_sel, cal_dis, cal_start, sleep, polar, coef_meas, gain_sel};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Record any acknowledge during a frame.
    always @(negedge clk) if (sdata_oe === 1'b1) ack_seen = 1'b1;

    task automatic frame(input logic [15:0] w, input int n);
        logic upd;
        upd = (n >= 16) && (w[7:0] == 8'h3C);
        ack_seen = 1'b0;
        @(negedge clk) sen = 1'b1;
        repeat (H) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sdata_in = (i < 16) ? w[i] : ~w[i % 16];
            repeat (H) @(negedge clk);
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            if (i == 15) begin
                check("R3 register loaded at 16th rise", fields_now(), upd ? w[15:8] : model);
                check("R4 no ack before fall", sdata_oe, 0);
            end
            sclk = 1'b0;
            repeat (H) @(negedge clk);
            if (i == 15) check("R4 ack after following fall", sdata_oe, upd);
            if (i == n - 1 && n > 16) check("R5 ack held during extra bits", sdata_oe, upd);
        end
        sen = 1'b0;
        sdata_in = 1'b1;
        repeat (2 * H) @(negedge clk);
        check("R5 ack released after enable low", sdata_oe, 0);
        check("R6 R8 ack only for accepted frame", ack_seen, upd);
        if (upd) model = w[15:8];
        check("R2 R6 R7 R8 R10 register after frame", fields_now(), model);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 fields after reset", fields_now(), 0);
        check("R1 ack after reset", sdata_oe, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        for (int v = 0; v < 7; v++) frame(VECS[v].w, int'(VECS[v].n));

        // R9: start clear drops only the start bit
        frame(16'hD73C, 16);
        check("R9 start bit set before clear", cal_start, 1);
        @(negedge clk) start_clr = 1'b1;
        @(negedge clk) start_clr = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 only start bit cleared", fields_now(), 8'hC7);

        // R1: reset in mid-run clears everything
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 fields after second reset", fields_now(), 0);
        rst_n = 1'b1;

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule